// File: doc/BRIEF.md
# Linear CCD Line Readout Sequencer

This block drives the clock pins of a 2592-pixel linear CCD from a fast system clock. Each line begins with a transfer-gate pulse that moves the integrated charge into the shift register. A quiet guard interval lies on each side of that pulse. The block then issues 2631 pixel-clock periods, and each period shifts one position out of the sensor.

When external reset is enabled, the block places one reset pulse inside the low half of every pixel period. The pixel-clock half period, gate width, guard length and reset placement are all counts of system-clock cycles. They are captured when a line starts.

Alongside the pulses, the block outputs a line-valid flag, a 12-bit pixel index and four exclusive region flags, so that a downstream sampler can tag each value. A single start pulse reads out one line. With continuous mode held high, the next line begins straight after the trailing positions, so the integration time equals the line period. All counts must be at least 1.

Top module: `ccd_line_timer`

## Requirements
- R1: While rst_ni is low, and right after it goes low in the middle of a line, every output is 0: gate, pixel clock, reset pulse, line valid, pixel index, region flags and end-of-line.
- R2: A start sampled in idle on clock edge E makes xfer_gate_o rise on edge E+G, where G is the guard count. The gate then stays high for exactly the gate count of cycles.
- R3: The first pixel-clock rise comes exactly G cycles after xfer_gate_o falls. During the guard, gate and idle periods, pclk_o and line_valid_o are low.
- R4: In each pixel period, pclk_o is high for H cycles and then low for H cycles, where H is the half count. Each line has exactly 2631 rising edges.
- R5: pix_idx_o is 0 at the first rise and steps by 1 on every later rise, up to 2630. It changes in the same cycle as the rise. line_valid_o is high from the first rise until the end of the last low half.
- R6: While line_valid_o is high, exactly one region flag is set. ob_o is set for indices 12..29. lead_o is set for indices 0..11 and 30..32. eff_o is set for indices 33..2624. trail_o is set for indices 2625..2630. All four flags are 0 while line_valid_o is low.
- R7: eol_o is high for exactly one cycle, in the cycle where line_valid_o falls after index 2630.
- R8: With cont_i low at the end of a line, the block returns to idle and no further gate pulse appears. With cont_i high, the next line's guard starts on that same edge, and its gate rises G cycles later.
- R9: With reset enabled for the line, pix_rst_o is high in each pixel's low half for offsets L to L+W-1 counted from the falling edge, where L is the reset lead and W is the reset width. With reset disabled, pix_rst_o stays 0.
- R10: Count, reset-enable and reset-placement inputs are captured only when a line starts. Changes made during a line have no effect on that line.
- R11: A start pulse that arrives while a line is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one line when the block is idle |
| cont_i | input | 1 | Continuous mode; sampled at the end of each line |
| rs_en_i | input | 1 | Enables the per-pixel reset pulse |
| half_cnt_i | input | 16 | Pixel-clock half period, in cycles |
| gate_cnt_i | input | 16 | Transfer-gate high time, in cycles |
| guard_cnt_i | input | 16 | Guard interval on each side of the gate, in cycles |
| rs_lead_i | input | 16 | Reset-pulse offset after the pixel-clock fall, in cycles |
| rs_wid_i | input | 16 | Reset-pulse width, in cycles |
| xfer_gate_o | output | 1 | Line-start transfer-gate pulse |
| pclk_o | output | 1 | Pixel shift clock |
| pix_rst_o | output | 1 | Per-pixel reset pulse |
| line_valid_o | output | 1 | High while pixels are being shifted out |
| pix_idx_o | output | 12 | Index of the current pixel |
| lead_o | output | 1 | Leading dummy position, optical black excluded |
| ob_o | output | 1 | Optical-black position |
| eff_o | output | 1 | Effective pixel |
| trail_o | output | 1 | Trailing dummy position |
| eol_o | output | 1 | One-cycle end-of-line pulse |

## Verification
In continuous mode, two events fall on the same edge: the end-of-line pulse of one line, and the parameter capture and guard start of the next. The bench provokes this by running two lines back to back with cont_i high. It then expects the cycle that carries eol_o to be the first guard cycle of the next line, with the gate rising exactly G cycles later. The reset pulse can also coincide with the pixel-clock fall, when the lead is 0 and H is 1. The bench judges each cycle's pix_rst_o against that cycle's pixel-clock phase.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;
  parameter int unsigned CNT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GATE, ST_POST, ST_SHIFT
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] gate;
    logic [CNT_W-1:0] guard;
    logic [CNT_W-1:0] rs_lead;
    logic [CNT_W-1:0] rs_wid;
    logic             rs_en;
  } line_cfg_t;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timing_pkg::*;
#(
  parameter int unsigned N_LINE = 2631,
  parameter int unsigned IDX_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  line_cfg_t        cfg_i,
  output line_cfg_t        cfg_o,
  output logic             gate_o,
  output logic             pclk_o,
  output logic             lv_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             eol_o,
  output logic [CNT_W:0]   cnt_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LINE - 1);

  seq_state_e       state_q;
  line_cfg_t        cfg_q;
  logic [CNT_W:0]   cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             gate_q, pclk_q, lv_q, eol_q;

  logic [CNT_W:0] guard_end, gate_end, half_end, per_end;
  assign guard_end = {1'b0, cfg_q.guard} - 1'b1;
  assign gate_end  = {1'b0, cfg_q.gate} - 1'b1;
  assign half_end  = {1'b0, cfg_q.half} - 1'b1;
  assign per_end   = {cfg_q.half, 1'b0} - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      gate_q  <= 1'b0;
      pclk_q  <= 1'b0;
      lv_q    <= 1'b0;
      eol_q   <= 1'b0;
    end else begin
      eol_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cfg_q   <= cfg_i;
            cnt_q   <= '0;
            state_q <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (cnt_q == guard_end) begin
            cnt_q   <= '0;
            gate_q  <= 1'b1;
            state_q <= ST_GATE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_GATE: begin
          if (cnt_q == gate_end) begin
            cnt_q   <= '0;
            gate_q  <= 1'b0;
            state_q <= ST_POST;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_POST: begin
          if (cnt_q == guard_end) begin
            cnt_q   <= '0;
            pclk_q  <= 1'b1;
            lv_q    <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_SHIFT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SHIFT: begin
          if (cnt_q == half_end) begin
            pclk_q <= 1'b0;
            cnt_q  <= cnt_q + 1'b1;
          end else if (cnt_q == per_end) begin
            cnt_q <= '0;
            if (idx_q == LAST_IDX) begin
              lv_q  <= 1'b0;
              idx_q <= '0;
              eol_q <= 1'b1;
              if (cont_i) begin
                cfg_q   <= cfg_i;
                state_q <= ST_PRE;
              end else state_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_q + 1'b1;
              pclk_q <= 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_o  = cfg_q;
  assign gate_o = gate_q;
  assign pclk_o = pclk_q;
  assign lv_o   = lv_q;
  assign idx_o  = idx_q;
  assign eol_o  = eol_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ccd_region_dec.sv
module ccd_region_dec #(
  parameter int unsigned N_LEAD   = 33,
  parameter int unsigned N_EFF    = 2592,
  parameter int unsigned OB_FIRST = 12,
  parameter int unsigned N_OB     = 18,
  parameter int unsigned IDX_W    = 12
) (
  input  logic             lv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             lead_o,
  output logic             ob_o,
  output logic             eff_o,
  output logic             trail_o
);
  localparam logic [IDX_W-1:0] EFF_LO = IDX_W'(N_LEAD);
  localparam logic [IDX_W-1:0] TRL_LO = IDX_W'(N_LEAD + N_EFF);

  logic in_ob;
  generate
    if (N_OB > 0) begin : g_ob
      localparam logic [IDX_W-1:0] OB_LO = IDX_W'(OB_FIRST);
      localparam logic [IDX_W-1:0] OB_HI = IDX_W'(OB_FIRST + N_OB);
      assign in_ob = (idx_i >= OB_LO) && (idx_i < OB_HI);
    end else begin : g_no_ob
      assign in_ob = 1'b0;
    end
  endgenerate

  assign ob_o    = lv_i && in_ob;
  assign lead_o  = lv_i && !in_ob && (idx_i < EFF_LO);
  assign eff_o   = lv_i && (idx_i >= EFF_LO) && (idx_i < TRL_LO);
  assign trail_o = lv_i && (idx_i >= TRL_LO);
endmodule

// File: rtl/ccd_rst_pulse.sv
module ccd_rst_pulse
  import ccd_timing_pkg::*;
(
  input  logic             en_i,
  input  logic             lv_i,
  input  logic             pclk_i,
  input  logic [CNT_W:0]   cnt_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             rs_o
);
  logic [CNT_W:0] off, lo, hi;
  // offset within the low half of the pixel period
  assign off  = cnt_i - {1'b0, half_i};
  assign lo   = {1'b0, lead_i};
  assign hi   = lo + {1'b0, wid_i};
  assign rs_o = en_i && lv_i && !pclk_i && (off >= lo) && (off < hi);
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timing_pkg::*;
#(
  parameter int unsigned N_LEAD   = 33,
  parameter int unsigned N_EFF    = 2592,
  parameter int unsigned N_TRAIL  = 6,
  parameter int unsigned OB_FIRST = 12,
  parameter int unsigned N_OB     = 18,
  parameter int unsigned IDX_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             rs_en_i,
  input  logic [CNT_W-1:0] half_cnt_i,
  input  logic [CNT_W-1:0] gate_cnt_i,
  input  logic [CNT_W-1:0] guard_cnt_i,
  input  logic [CNT_W-1:0] rs_lead_i,
  input  logic [CNT_W-1:0] rs_wid_i,
  output logic             xfer_gate_o,
  output logic             pclk_o,
  output logic             pix_rst_o,
  output logic             line_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             lead_o,
  output logic             ob_o,
  output logic             eff_o,
  output logic             trail_o,
  output logic             eol_o
);
  localparam int unsigned N_LINE = N_LEAD + N_EFF + N_TRAIL;

  line_cfg_t      cfg_in, cfg_q;
  logic [CNT_W:0] cnt;

  assign cfg_in = '{half: half_cnt_i, gate: gate_cnt_i, guard: guard_cnt_i,
                    rs_lead: rs_lead_i, rs_wid: rs_wid_i, rs_en: rs_en_i};

  ccd_line_seq #(.N_LINE(N_LINE), .IDX_W(IDX_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .cont_i,
    .cfg_i(cfg_in), .cfg_o(cfg_q),
    .gate_o(xfer_gate_o), .pclk_o(pclk_o), .lv_o(line_valid_o),
    .idx_o(pix_idx_o), .eol_o(eol_o), .cnt_o(cnt)
  );

  ccd_region_dec #(
    .N_LEAD(N_LEAD), .N_EFF(N_EFF), .OB_FIRST(OB_FIRST), .N_OB(N_OB), .IDX_W(IDX_W)
  ) i_dec (
    .lv_i(line_valid_o), .idx_i(pix_idx_o),
    .lead_o, .ob_o, .eff_o, .trail_o
  );

  ccd_rst_pulse i_rs (
    .en_i(cfg_q.rs_en), .lv_i(line_valid_o), .pclk_i(pclk_o), .cnt_i(cnt),
    .half_i(cfg_q.half), .lead_i(cfg_q.rs_lead), .wid_i(cfg_q.rs_wid),
    .rs_o(pix_rst_o)
  );
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int unsigned N_LINE = 2631,
  parameter int unsigned IDX_W  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_gate_o,
  input logic             pclk_o,
  input logic             pix_rst_o,
  input logic             line_valid_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             lead_o,
  input logic             ob_o,
  input logic             eff_o,
  input logic             trail_o,
  input logic             eol_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINE - 1);

  AST_REGION_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> $countones({lead_o, ob_o, eff_o, trail_o}) == 1); // R6
  AST_REGION_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_o |-> {lead_o, ob_o, eff_o, trail_o} == 4'b0); // R6
  AST_GATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_gate_o |-> !pclk_o && !line_valid_o); // R3
  AST_PCLK_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> line_valid_o); // R4
  AST_RS_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_rst_o |-> line_valid_o && !pclk_o); // R9
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> pix_idx_o <= LAST); // R5
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_o) && $past(line_valid_o) |-> pix_idx_o == $past(pix_idx_o) + 1'b1); // R5
  AST_EOL_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> !line_valid_o && $past(line_valid_o) && $past(pix_idx_o) == LAST); // R7
endmodule

bind ccd_line_timer ccd_line_timer_chk #(.N_LINE(N_LINE), .IDX_W(IDX_W)) i_chk (
  .clk_i, .rst_ni, .xfer_gate_o, .pclk_o, .pix_rst_o, .line_valid_o,
  .pix_idx_o, .lead_o, .ob_o, .eff_o, .trail_o, .eol_o
);

// File: tb/test_ccd_line_timer.sv
`timescale 1ns/1ps
module test_ccd_line_timer;
  localparam int NL = 2631;

  typedef struct packed {
    logic gate, pclk, rs, lv;
    logic [11:0] idx;
    logic lead, ob, eff, trail, eol;
  } smp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, cont_i = 1'b0, rs_en_i = 1'b0;
  logic [15:0] half_cnt_i = 16'd2, gate_cnt_i = 16'd4, guard_cnt_i = 16'd3;
  logic [15:0] rs_lead_i = 16'd0, rs_wid_i = 16'd1;
  logic xfer_gate_o, pclk_o, pix_rst_o, line_valid_o, lead_o, ob_o, eff_o, trail_o, eol_o;
  logic [11:0] pix_idx_o;

  int checks = 0, fails = 0;
  smp_t q[$];

  always #2.5 clk_i = ~clk_i;

  ccd_line_timer i_ccd_line_timer (.*);

  function automatic smp_t actual();
    smp_t a;
    a = '{gate: xfer_gate_o, pclk: pclk_o, rs: pix_rst_o, lv: line_valid_o, idx: pix_idx_o,
          lead: lead_o, ob: ob_o, eff: eff_o, trail: trail_o, eol: eol_o};
    return a;
  endfunction

  // monitor: pops one expected cycle and compares it
  always @(negedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      smp_t e, a;
      string tag;
      e = q.pop_front();
      a = actual();
      checks++;
      if (a !== e) begin
        fails++;
        if (a.gate !== e.gate) tag = "R2";
        else if (a.pclk !== e.pclk) tag = "R4";
        else if (a.lv !== e.lv || a.idx !== e.idx) tag = "R5";
        else if (a.rs !== e.rs) tag = "R9";
        else if (a.eol !== e.eol) tag = "R7";
        else tag = "R6";
        if (fails < 20)
          $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, a, e);
      end
    end
  end

  task automatic chk_idle(input string tag);
    checks++;
    if (actual() !== '0) begin
      fails++;
      $display("FAIL %s idle outputs actual=%h expected=0", tag, actual());
    end
  endtask

  function automatic smp_t pix_smp(int p, int s, int h, bit en, int ld, int wd);
    smp_t e = '0;
    e.lv = 1'b1; e.idx = 12'(p); e.pclk = (s < h);
    e.rs = en && (s >= h + ld) && (s < h + ld + wd);
    if (p >= 12 && p < 30) e.ob = 1'b1;
    else if (p < 33) e.lead = 1'b1;
    else if (p < 2625) e.eff = 1'b1;
    else e.trail = 1'b1;
    return e;
  endfunction

  // driver side: expected trace of one line, sample 0 = first guard cycle
  task automatic push_line(int h, int gd, int gt, bit en, int ld, int wd, bit eol0);
    smp_t z = '0, g = '0;
    g.gate = 1'b1;
    z.eol = eol0; q.push_back(z); z.eol = 1'b0;
    for (int k = 1; k < gd; k++) q.push_back(z);   // R2 guard before gate
    for (int k = 0; k < gt; k++) q.push_back(g);
    for (int k = 0; k < gd; k++) q.push_back(z);   // R3 guard after gate
    for (int p = 0; p < NL; p++)
      for (int s = 0; s < 2 * h; s++) q.push_back(pix_smp(p, s, h, en, ld, wd));
  endtask

  task automatic push_end(int n_idle);
    smp_t z = '0;
    z.eol = 1'b1; q.push_back(z); z.eol = 1'b0;
    for (int k = 0; k < n_idle; k++) q.push_back(z);   // R8 no restart
  endtask

  task automatic set_cfg(int h, int gd, int gt, bit en, int ld, int wd);
    half_cnt_i = 16'(h); guard_cnt_i = 16'(gd); gate_cnt_i = 16'(gt);
    rs_en_i = en; rs_lead_i = 16'(ld); rs_wid_i = 16'(wd);
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (120000) @(posedge clk_i);
    fails++;
    $display("FAIL R5 watchdog expired: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_idle("R1");

    // single line, reset pulse off (R2 R3 R4 R5 R6 R7 R8)
    set_cfg(2, 3, 4, 1'b0, 0, 1);
    pulse_start();
    push_line(2, 3, 4, 1'b0, 0, 1, 1'b0);
    push_end(10);
    drain();

    // reset pulse on; mid-line config change and extra start (R9 R10 R11)
    set_cfg(3, 2, 2, 1'b1, 1, 1);
    pulse_start();
    push_line(3, 2, 2, 1'b1, 1, 1, 1'b0);
    push_end(10);
    repeat (50) @(negedge clk_i);
    set_cfg(5, 7, 9, 1'b0, 0, 2);
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    drain();

    // continuous mode, back-to-back lines, H=1, lead 0 (R8 R7 R9)
    set_cfg(1, 1, 1, 1'b1, 0, 1);
    cont_i = 1'b1;
    pulse_start();
    push_line(1, 1, 1, 1'b1, 0, 1, 1'b0);
    push_line(1, 1, 1, 1'b1, 0, 1, 1'b1);
    push_end(10);
    repeat (6000) @(negedge clk_i);
    cont_i = 1'b0;
    drain();

    // reset in the middle of a line (R1)
    set_cfg(2, 2, 2, 1'b1, 0, 1);
    pulse_start();
    repeat (300) @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk_idle("R1");
    repeat (2) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk_idle("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule